// File: doc/BRIEF.md
# CSR Burst Transfer Engine

This engine sits inside a chain target, between the queues that hold incoming transfer requests and write-data words and a local register block. It takes one request at a time and runs it on a two-phase local interface. Every burst is cut into single-word chunks. Each chunk has a command phase, which ends on an acknowledge, and a data phase, which ends on a valid or an error. Only one chunk is in flight at any time.

When a transfer finishes, the engine pushes a response entry toward the target's response queue. Reads produce one OK entry per chunk, carrying the read data. Writes produce one OK entry when the whole burst is done. The first error ends the burst with an ERROR entry, and any write words the burst had not yet used are dropped. A rising interrupt line causes the current read-data value to be pushed as an interrupt vector. This goes out on a separate urgent port, which the queue places ahead of the responses already waiting in it.

Top module: `csr_burst_engine`

## Requirements
- R1: `csr_cmd_o` is 2'b00 when idle, 2'b01 for a read and 2'b10 for a write. The value 2'b11 never appears.
- R2: When a non-idle command is acknowledged, `csr_cmd_o` is idle from the next cycle until that chunk's data phase ends with valid or error.
- R3: Acknowledge, valid and error inputs are ignored while `csr_cmd_o` is idle and no data phase is pending. They cause no response, no pop and no change to the chunk address or the count.
- R4: For a write chunk, `csr_wdata_o` shows the head write-data word during the command phase. That word is popped (`wd_pop_o` high) in the acknowledge cycle.
- R5: In an incrementing burst (`req_same_i`=0), chunk k uses address start+k, modulo 2^AW.
- R6: In a same-address burst (`req_same_i`=1), every chunk uses the start address and `csr_same_o` is 1.
- R7: `req_size_i` holds the number of chunks minus one. `csr_rem_o` shows the number of chunks that follow the current one: `req_size_i` on the first chunk, falling by one per chunk, and 0 on the last.
- R8: A read pushes one response with `rsp_err_o`=0 in each cycle that a read chunk gets valid. `rsp_data_o` equals `csr_rdata_i` in that cycle.
- R9: A write pushes exactly one response with `rsp_err_o`=0 and `rsp_data_o`=0. The push happens in the cycle that the last chunk gets valid.
- R10: An error in a data phase pushes a response with `rsp_err_o`=1 in that same cycle. No further command of that burst is issued. All unused write words of the burst are popped and discarded, so a burst of N chunks pops exactly N words.
- R11: Every response carries the `req_tid_i` and `req_tgt_i` of the request that produced it.
- R12: Each rising edge of `csr_irq_i` gives exactly one `irq_push_o` pulse, one cycle after the edge. `irq_vec_o` holds the value of `csr_rdata_i` at the edge. No pulse follows while the line stays high.
- R13: A write chunk drives `csr_cmd_o` idle for as long as `wd_vld_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Request queue has an entry |
| req_wr_i | input | 1 | Request is a write |
| req_same_i | input | 1 | Request is a same-address burst |
| req_size_i | input | SW | Chunk count minus one |
| req_addr_i | input | AW | Start address |
| req_tid_i | input | TIDW | Transaction ID |
| req_tgt_i | input | TGTW | Target ID |
| req_pop_o | output | 1 | Take the head request |
| wd_vld_i | input | 1 | Write-data queue has an entry |
| wd_data_i | input | DW | Head write-data word |
| wd_pop_o | output | 1 | Take the head write word |
| csr_addr_o | output | AW | Chunk address |
| csr_cmd_o | output | 2 | Command code |
| csr_wdata_o | output | DW | Write data |
| csr_same_o | output | 1 | Same-address burst flag |
| csr_rem_o | output | SW | Chunks left after the current one |
| csr_ack_i | input | 1 | Command acknowledge |
| csr_rdata_i | input | DW | Read data or interrupt vector |
| csr_vld_i | input | 1 | Data phase done |
| csr_err_i | input | 1 | Data phase failed |
| csr_irq_i | input | 1 | Interrupt line |
| rsp_push_o | output | 1 | Push a response to the queue tail |
| rsp_err_o | output | 1 | 1 for ERROR, 0 for OK |
| rsp_tid_o | output | TIDW | Response transaction ID |
| rsp_tgt_o | output | TGTW | Response target ID |
| rsp_data_o | output | DW | Response data |
| irq_push_o | output | 1 | Push an interrupt to the queue head |
| irq_vec_o | output | DW | Interrupt vector |

## Verification
The hardest case to reach is an error in the middle of a write burst. The engine has already consumed some write words by then, and it must drain exactly the rest without issuing any further command. The sweep injects an error at every chunk position of several write bursts. It checks the cycle of the ERROR response, that the command stays idle afterward, and that the total number of words popped equals the burst length. Spurious acknowledge, valid and error pulses are driven during idle and waiting cycles across the whole sweep, and none of them may cause a response or a step.

// File: rtl/csr_beng_pkg.sv
`timescale 1ns/1ps
package csr_beng_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10
  } csr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_FLUSH
  } beng_st_e;
endpackage

// File: rtl/csr_beng_walk.sv
`timescale 1ns/1ps
module csr_beng_walk #(
  parameter int AW = 8,
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] size_i,
  input  logic          same_i,
  output logic [AW-1:0] addr_o,
  output logic [SW-1:0] rem_o,
  output logic          same_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [SW-1:0] rem_q;
  logic          same_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
      same_q <= 1'b0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= size_i;
      same_q <= same_i;
    end else if (step_i) begin
      rem_q <= rem_q - 1'b1;
      if (!same_q) addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign rem_o  = rem_q;
  assign same_o = same_q;
  assign last_o = (rem_q == '0);

  // R7
  step_not_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o);
  // R5
  seq_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !same_q) |=> (addr_q == $past(addr_q) + 1'b1));
  // R6
  same_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && same_q) |=> $stable(addr_q));
endmodule

// File: rtl/csr_beng_irq.sv
`timescale 1ns/1ps
module csr_beng_irq #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic [DW-1:0] vec_i,
  output logic          push_o,
  output logic [DW-1:0] vec_o
);
  logic          irq_q, push_q;
  logic [DW-1:0] vec_q;
  logic          rise;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      push_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      irq_q  <= irq_i;
      push_q <= rise;
      if (rise) vec_q <= vec_i;
    end
  end

  assign push_o = push_q;
  assign vec_o  = vec_q;

  // R12
  irq_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
endmodule

// File: rtl/csr_beng_ctrl.sv
`timescale 1ns/1ps
module csr_beng_ctrl
  import csr_beng_pkg::*;
#(
  parameter int SW   = 3,
  parameter int DW   = 8,
  parameter int TIDW = 4,
  parameter int TGTW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_vld_i,
  input  logic            req_wr_i,
  input  logic [TIDW-1:0] req_tid_i,
  input  logic [TGTW-1:0] req_tgt_i,
  output logic            req_pop_o,
  input  logic            wd_vld_i,
  output logic            wd_pop_o,
  input  logic            last_i,
  input  logic [SW-1:0]   rem_i,
  output logic            step_o,
  output logic [1:0]      csr_cmd_o,
  input  logic            csr_ack_i,
  input  logic            csr_vld_i,
  input  logic            csr_err_i,
  input  logic [DW-1:0]   csr_rdata_i,
  output logic            rsp_push_o,
  output logic            rsp_err_o,
  output logic [TIDW-1:0] rsp_tid_o,
  output logic [TGTW-1:0] rsp_tgt_o,
  output logic [DW-1:0]   rsp_data_o
);
  beng_st_e        st_q;
  logic            wr_q;
  logic [TIDW-1:0] tid_q;
  logic [TGTW-1:0] tgt_q;
  logic [SW-1:0]   fl_q;

  logic cmd_live, acc, fin_err, fin_ok, fl_pop;
  csr_cmd_e cmd;

  always_comb begin
    req_pop_o = (st_q == ST_IDLE) && req_vld_i;
    cmd_live  = (st_q == ST_CMD) && (!wr_q || wd_vld_i);
    if (!cmd_live)  cmd = CMD_IDLE;
    else if (wr_q)  cmd = CMD_WR;
    else            cmd = CMD_RD;
    acc       = cmd_live && csr_ack_i;
    fin_err   = (st_q == ST_DATA) && csr_err_i;
    fin_ok    = (st_q == ST_DATA) && !csr_err_i && csr_vld_i;
    fl_pop    = (st_q == ST_FLUSH) && wd_vld_i;
    step_o    = fin_ok && !last_i;
    wd_pop_o  = (acc && wr_q) || fl_pop;
    rsp_push_o = fin_err || (fin_ok && (!wr_q || last_i));
    rsp_err_o  = fin_err;
    rsp_data_o = (fin_ok && !wr_q) ? csr_rdata_i : '0;
  end

  assign csr_cmd_o = cmd;
  assign rsp_tid_o = tid_q;
  assign rsp_tgt_o = tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      wr_q  <= 1'b0;
      tid_q <= '0;
      tgt_q <= '0;
      fl_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_vld_i) begin
          wr_q  <= req_wr_i;
          tid_q <= req_tid_i;
          tgt_q <= req_tgt_i;
          st_q  <= ST_CMD;
        end
        ST_CMD: if (acc) st_q <= ST_DATA;
        ST_DATA: begin
          if (fin_err) begin
            // drop write words the cancelled chunks would have used
            if (wr_q && !last_i) begin
              fl_q <= rem_i;
              st_q <= ST_FLUSH;
            end else begin
              st_q <= ST_IDLE;
            end
          end else if (fin_ok) begin
            st_q <= last_i ? ST_IDLE : ST_CMD;
          end
        end
        ST_FLUSH: if (fl_pop) begin
          fl_q <= fl_q - 1'b1;
          if (fl_q == SW'(1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  cmd_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_cmd_o != 2'b11);
  // R2
  one_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_cmd_o != 2'b00 && csr_ack_i) |=> csr_cmd_o == 2'b00);
  // R13
  data_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_pop_o |-> wd_vld_i);
  // R10
  err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_push_o && rsp_err_o) |=> csr_cmd_o == 2'b00);
endmodule

// File: rtl/csr_burst_engine.sv
`timescale 1ns/1ps
module csr_burst_engine #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int SW   = 3,
  parameter int TIDW = 4,
  parameter int TGTW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_vld_i,
  input  logic            req_wr_i,
  input  logic            req_same_i,
  input  logic [SW-1:0]   req_size_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [TIDW-1:0] req_tid_i,
  input  logic [TGTW-1:0] req_tgt_i,
  output logic            req_pop_o,
  input  logic            wd_vld_i,
  input  logic [DW-1:0]   wd_data_i,
  output logic            wd_pop_o,
  output logic [AW-1:0]   csr_addr_o,
  output logic [1:0]      csr_cmd_o,
  output logic [DW-1:0]   csr_wdata_o,
  output logic            csr_same_o,
  output logic [SW-1:0]   csr_rem_o,
  input  logic            csr_ack_i,
  input  logic [DW-1:0]   csr_rdata_i,
  input  logic            csr_vld_i,
  input  logic            csr_err_i,
  input  logic            csr_irq_i,
  output logic            rsp_push_o,
  output logic            rsp_err_o,
  output logic [TIDW-1:0] rsp_tid_o,
  output logic [TGTW-1:0] rsp_tgt_o,
  output logic [DW-1:0]   rsp_data_o,
  output logic            irq_push_o,
  output logic [DW-1:0]   irq_vec_o
);
  logic          step, last;
  logic [SW-1:0] rem;
  logic [1:0]    cmd;

  csr_beng_walk #(.AW(AW), .SW(SW)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (req_pop_o),
    .step_i (step),
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .same_i (req_same_i),
    .addr_o (csr_addr_o),
    .rem_o  (rem),
    .same_o (csr_same_o),
    .last_o (last)
  );

  csr_beng_ctrl #(.SW(SW), .DW(DW), .TIDW(TIDW), .TGTW(TGTW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_vld_i   (req_vld_i),
    .req_wr_i    (req_wr_i),
    .req_tid_i   (req_tid_i),
    .req_tgt_i   (req_tgt_i),
    .req_pop_o   (req_pop_o),
    .wd_vld_i    (wd_vld_i),
    .wd_pop_o    (wd_pop_o),
    .last_i      (last),
    .rem_i       (rem),
    .step_o      (step),
    .csr_cmd_o   (cmd),
    .csr_ack_i   (csr_ack_i),
    .csr_vld_i   (csr_vld_i),
    .csr_err_i   (csr_err_i),
    .csr_rdata_i (csr_rdata_i),
    .rsp_push_o  (rsp_push_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_tid_o   (rsp_tid_o),
    .rsp_tgt_o   (rsp_tgt_o),
    .rsp_data_o  (rsp_data_o)
  );

  csr_beng_irq #(.DW(DW)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (csr_irq_i),
    .vec_i  (csr_rdata_i),
    .push_o (irq_push_o),
    .vec_o  (irq_vec_o)
  );

  assign csr_cmd_o   = cmd;
  assign csr_rem_o   = rem;
  assign csr_wdata_o = (cmd == 2'b10) ? wd_data_i : '0;
endmodule

// File: tb/sim_csr_burst_engine.sv
`timescale 1ns/1ps
module sim_csr_burst_engine;
  localparam int AW = 8, DW = 8, SW = 3, TIDW = 4, TGTW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_vld_i = 0, req_wr_i = 0, req_same_i = 0;
  logic [SW-1:0] req_size_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [TIDW-1:0] req_tid_i = '0;
  logic [TGTW-1:0] req_tgt_i = '0;
  logic req_pop_o, wd_pop_o;
  logic wd_vld_i = 0;
  logic [DW-1:0] wd_data_i = '0;
  logic [AW-1:0] csr_addr_o;
  logic [1:0] csr_cmd_o;
  logic [DW-1:0] csr_wdata_o;
  logic csr_same_o;
  logic [SW-1:0] csr_rem_o;
  logic csr_ack_i = 0, csr_vld_i = 0, csr_err_i = 0, csr_irq_i = 0;
  logic [DW-1:0] csr_rdata_i = '0;
  logic rsp_push_o, rsp_err_o, irq_push_o;
  logic [TIDW-1:0] rsp_tid_o;
  logic [TGTW-1:0] rsp_tgt_o;
  logic [DW-1:0] rsp_data_o, irq_vec_o;

  csr_burst_engine #(.AW(AW), .DW(DW), .SW(SW), .TIDW(TIDW), .TGTW(TGTW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_vld_i(req_vld_i), .req_wr_i(req_wr_i), .req_same_i(req_same_i),
    .req_size_i(req_size_i), .req_addr_i(req_addr_i), .req_tid_i(req_tid_i),
    .req_tgt_i(req_tgt_i), .req_pop_o(req_pop_o),
    .wd_vld_i(wd_vld_i), .wd_data_i(wd_data_i), .wd_pop_o(wd_pop_o),
    .csr_addr_o(csr_addr_o), .csr_cmd_o(csr_cmd_o), .csr_wdata_o(csr_wdata_o),
    .csr_same_o(csr_same_o), .csr_rem_o(csr_rem_o), .csr_ack_i(csr_ack_i),
    .csr_rdata_i(csr_rdata_i), .csr_vld_i(csr_vld_i), .csr_err_i(csr_err_i),
    .csr_irq_i(csr_irq_i), .rsp_push_o(rsp_push_o), .rsp_err_o(rsp_err_o),
    .rsp_tid_o(rsp_tid_o), .rsp_tgt_o(rsp_tgt_o), .rsp_data_o(rsp_data_o),
    .irq_push_o(irq_push_o), .irq_vec_o(irq_vec_o)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rdf(input logic [AW-1:0] a);
    return DW'(a) ^ 8'hA5;
  endfunction

  function automatic logic [DW-1:0] wdat(input int k);
    return DW'(8'h30 + 7 * k);
  endfunction

  task automatic run_burst(input bit wr, input bit same, input int size, input int addr,
                           input int ackd, input int datd, input int errc,
                           input int wgap, input bit noise, input int tid, input int tgt);
    int widx = 0, chunk = 0, ackcnt = 0, dwait = 0, tail = 0, cyc = 0, npop = 0;
    int wtot = wr ? size + 1 : 0;
    bit outst = 0, popped = 0, done = 0, acked, fin, ferr;
    logic [AW-1:0] cur_a = '0, exp_a;
    req_wr_i   = wr;
    req_same_i = same;
    req_size_i = SW'(size);
    req_addr_i = AW'(addr);
    req_tid_i  = TIDW'(tid);
    req_tgt_i  = TGTW'(tgt);
    while (tail < 10 && cyc < 300) begin
      @(negedge clk);
      cyc++;
      req_vld_i = !popped;
      wd_vld_i  = (widx < wtot) && (cyc > wgap);
      wd_data_i = wdat(widx);
      csr_ack_i = 0; csr_vld_i = 0; csr_err_i = 0; csr_rdata_i = 8'h00;
      acked = 0; fin = 0; ferr = 0;
      #1;
      if (wr && !wd_vld_i)
        chk(csr_cmd_o == 2'b00, "R13 cmd idle without write data", int'(csr_cmd_o), 0);
      if (done && tail > 0)
        chk(csr_cmd_o == 2'b00, "R10 no command after burst end", int'(csr_cmd_o), 0);
      if (outst) begin
        dwait++;
        if (dwait > datd) begin
          fin = 1;
          if (chunk == errc) begin csr_err_i = 1; ferr = 1; end
          else begin csr_vld_i = 1; csr_rdata_i = rdf(cur_a); end
        end else if (noise) csr_ack_i = 1;
        chk(csr_cmd_o == 2'b00, "R2 idle while data pending", int'(csr_cmd_o), 0);
      end else if (csr_cmd_o != 2'b00 && !done) begin
        ackcnt++;
        if (ackcnt > ackd) begin
          csr_ack_i = 1; acked = 1; ackcnt = 0;
          exp_a = AW'(addr + (same ? 0 : chunk));
          chk(csr_cmd_o == (wr ? 2'b10 : 2'b01), "R1 command code", int'(csr_cmd_o), wr ? 2 : 1);
          chk(csr_addr_o == exp_a, same ? "R6 same address" : "R5 incrementing address",
              int'(csr_addr_o), int'(exp_a));
          chk(csr_same_o == same, "R6 same flag", int'(csr_same_o), int'(same));
          chk(int'(csr_rem_o) == size - chunk, "R7 remaining count", int'(csr_rem_o), size - chunk);
          if (wr) chk(csr_wdata_o == wdat(chunk), "R4 write data with command",
                      int'(csr_wdata_o), int'(wdat(chunk)));
          cur_a = exp_a;
        end else if (noise) begin
          csr_vld_i = 1; csr_err_i = 1;
        end
      end else if (noise) begin
        csr_ack_i = 1; csr_vld_i = 1; csr_err_i = 1;
      end
      #1;
      begin
        bit exp_push = fin && (ferr || !wr || chunk == size);
        chk(rsp_push_o == exp_push, "R3 R8 R9 response push", int'(rsp_push_o), int'(exp_push));
        if (exp_push && rsp_push_o) begin
          chk(rsp_err_o == ferr, "R10 error flag", int'(rsp_err_o), int'(ferr));
          chk(int'(rsp_tid_o) == tid && int'(rsp_tgt_o) == tgt, "R11 response IDs",
              int'(rsp_tid_o), tid);
          if (!ferr && !wr)
            chk(rsp_data_o == rdf(cur_a), "R8 read data", int'(rsp_data_o), int'(rdf(cur_a)));
          else if (!ferr)
            chk(rsp_data_o == 0, "R9 write ok data", int'(rsp_data_o), 0);
        end
        if (acked && wr) chk(wd_pop_o == 1'b1, "R4 pop on acknowledge", int'(wd_pop_o), 1);
        if (!wr) chk(wd_pop_o == 1'b0, "R3 no pop on read", int'(wd_pop_o), 0);
      end
      if (req_pop_o) begin npop++; popped = 1; end
      if (wd_pop_o) widx++;
      if (acked) begin outst = 1; dwait = 0; end
      if (fin) begin
        outst = 0;
        if (ferr || chunk == size) done = 1; else chunk++;
      end
      if (done) tail++;
    end
    req_vld_i = 0; wd_vld_i = 0; csr_ack_i = 0; csr_vld_i = 0; csr_err_i = 0;
    chk(done, "R8 burst completed", int'(done), 1);
    chk(widx == wtot, "R10 write words consumed", widx, wtot);
    chk(npop == 1, "R11 single request pop", npop, 1);
  endtask

  task automatic irq_test(input logic [DW-1:0] vec, input int hold);
    @(negedge clk);
    csr_irq_i = 1; csr_rdata_i = vec;
    #1 chk(irq_push_o == 0, "R12 no push before edge", int'(irq_push_o), 0);
    @(negedge clk);
    csr_rdata_i = ~vec;
    #1;
    chk(irq_push_o == 1, "R12 push after edge", int'(irq_push_o), 1);
    chk(irq_vec_o == vec, "R12 vector captured", int'(irq_vec_o), int'(vec));
    for (int i = 0; i < hold + 3; i++) begin
      @(negedge clk);
      if (i == hold) csr_irq_i = 0;
      #1 chk(irq_push_o == 0, "R12 single push per edge", int'(irq_push_o), 0);
    end
    csr_rdata_i = '0;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(csr_cmd_o == 2'b00, "R1 reset command idle", int'(csr_cmd_o), 0);
    chk(rsp_push_o == 0 && irq_push_o == 0, "R8 reset no push", int'(rsp_push_o), 0);
    chk(req_pop_o == 0 && wd_pop_o == 0, "R3 reset no pop", int'(req_pop_o), 0);
    rst_ni = 1;
    // idle noise with no request: nothing may move
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      csr_ack_i = 1; csr_vld_i = 1; csr_err_i = i[0];
      #1;
      chk(rsp_push_o == 0 && req_pop_o == 0 && wd_pop_o == 0, "R3 idle noise ignored",
          int'(rsp_push_o), 0);
      chk(csr_cmd_o == 2'b00, "R3 idle noise no command", int'(csr_cmd_o), 0);
    end
    csr_ack_i = 0; csr_vld_i = 0; csr_err_i = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int same = 0; same < 2; same++)
        for (int size = 0; size < 8; size++)
          for (int d = 0; d < 6; d++)
            run_burst(wr[0], same[0], size, 250 - d, d % 2, d / 2, -1,
                      wr ? d : 0, size[0], (size + d) & 15, (wr * 4 + same + d) & 7);
    for (int wr = 0; wr < 2; wr++)
      for (int s = 1; s < 8; s += 3)
        for (int e = 0; e <= s; e++)
          run_burst(wr[0], 1'b0, s, 16 * e, e % 2, 1, e, 0, 1'b1, e & 15, s & 7);
    irq_test(8'h3C, 0);
    irq_test(8'hC3, 4);
    irq_test(8'h81, 1);
    finish_up();
  end
endmodule